// File: doc/BRIEF.md
# Cache Flush Sequencer

This block runs a whole-cache flush over the valid and dirty state of a small local cache. A flush starts with a single-cycle command that picks one of two kinds. The discard kind drops every line, modified or not. The writeback kind first sends each modified line out to memory and then drops it. Both kinds share one index walk. The walk puts a line index on the lookup port, reads back that line's valid and dirty bits in the same cycle, and pulses a clear strobe for the line once it has been handled.

The writeback kind raises a writeback request for each line that is both valid and dirty, and the walk stalls until the memory side acknowledges. Lines that are clean or invalid are cleared at once. When the last local line has been cleared, the sequencer asks the next cache level outward to flush itself and tells it which kind was requested. It holds that request until the outer level reports completion, pulses done, and goes back to idle. Commands that arrive while a flush is in progress are dropped.

Top module: `cache_flush_seq`

## Requirements
- R1: After reset, busy, done, line_clr, wb_req and outer_req are all low.
- R2: A cmd_valid pulse while idle is accepted: busy is high from the next cycle, stays high up to and including the done cycle, and is low after it.
- R3: The walk visits line indices 0 to LINES-1 in ascending order, and line_clr pulses exactly once for each index.
- R4: With cmd_wb = 0 (discard), wb_req never rises, and every line is left invalid, dirty ones included.
- R5: With cmd_wb = 1 (writeback), wb_req rises for each line whose valid and dirty bits are both 1, while line_idx shows that line. The line's clear comes only in the cycle wb_ack is high.
- R6: A clean (dirty = 0) or invalid (valid = 0) line never raises wb_req and is cleared in the cycle it is visited.
- R7: While wb_req is high and wb_ack is low, line_idx holds its value and wb_req stays high.
- R8: outer_req rises only after every local line has been cleared. outer_wb equals the cmd_wb of the accepted command, and outer_req stays high until the cycle outer_done is seen.
- R9: done is high for exactly one cycle, the cycle after outer_done is seen, and busy is low from the next cycle.
- R10: cmd_valid while busy has no effect: the running flush keeps its kind and writeback count, and no second flush follows.
- R11: A flush keeps busy high for LINES + W*(A+1) + (B+1) + 1 cycles. W is the number of writebacks, A is the number of cycles wb_ack lags wb_req, and B is the number of cycles outer_done lags outer_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Single-cycle flush command |
| cmd_wb | input | 1 | Flush kind: 1 = writeback then invalidate, 0 = discard |
| line_idx | output | $clog2(LINES) | Index of the line being visited |
| line_vld | input | 1 | Valid bit of the line at line_idx |
| line_dirty | input | 1 | Dirty bit of the line at line_idx |
| line_clr | output | 1 | Clear the valid and dirty bits of the line at line_idx |
| wb_req | output | 1 | Write back the line at line_idx |
| wb_ack | input | 1 | Writeback complete |
| outer_req | output | 1 | Request for the outer cache level to flush |
| outer_wb | output | 1 | Kind of flush requested from the outer level |
| outer_done | input | 1 | Outer level flush complete |
| busy | output | 1 | Flush in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Busy is due one cycle after the command edge. Each line clear lands in the same cycle as its lookup, or, for a modified line, in the cycle its acknowledge arrives. done follows outer_done by one cycle. The bench's responders return wb_ack and outer_done a set number of cycles after each request. Every edge-side effect (clears, writebacks, index order, stalls, the outer request) is recorded by a monitor on the clock edge where it happens. Totals and flags are compared on a falling edge once done has gone by. The busy-cycle count is checked against the R11 formula, which pins every stall to its exact cycle.

// File: rtl/cinv_pkg.sv
package cinv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_WB_WAIT,
        ST_OUTER,
        ST_DONE
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    mode_wb;
    } seq_reg_t;
endpackage

// File: rtl/cinv_walk.sv
module cinv_walk #(
    parameter int LINES = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (start)
            idx_d = '0;
        else if (step)
            idx_d = last ? '0 : idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else
            idx_q <= idx_d;
    end

    assign idx  = idx_q;
    assign last = (idx_q == IDX_W'(LINES - 1));

    // R3
    walk_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && !last) |=> (idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/cinv_line_eval.sv
module cinv_line_eval (
    input  logic mode_wb,
    input  logic vld,
    input  logic dirty,
    output logic need_wb
);
    assign need_wb = mode_wb & vld & dirty;
endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq #(
    parameter int LINES = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_wb,
    output logic [IDX_W-1:0] line_idx,
    input  logic             line_vld,
    input  logic             line_dirty,
    output logic             line_clr,
    output logic             wb_req,
    input  logic             wb_ack,
    output logic             outer_req,
    output logic             outer_wb,
    input  logic             outer_done,
    output logic             busy,
    output logic             done
);
    import cinv_pkg::*;

    seq_reg_t r_d, r_q;
    logic     walk_start, walk_step, walk_last, need_wb;

    cinv_walk #(.LINES(LINES)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .start (walk_start),
        .step  (walk_step),
        .idx   (line_idx),
        .last  (walk_last)
    );

    cinv_line_eval u_eval (
        .mode_wb (r_q.mode_wb),
        .vld     (line_vld),
        .dirty   (line_dirty),
        .need_wb (need_wb)
    );

    always_comb begin
        r_d        = r_q;
        walk_start = 1'b0;
        walk_step  = 1'b0;
        line_clr   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.st      = ST_WALK;
                    r_d.mode_wb = cmd_wb;
                    walk_start  = 1'b1;
                end
            end
            ST_WALK: begin
                if (need_wb) begin
                    r_d.st = ST_WB_WAIT;
                end else begin
                    line_clr  = 1'b1;
                    walk_step = 1'b1;
                    if (walk_last)
                        r_d.st = ST_OUTER;
                end
            end
            ST_WB_WAIT: begin
                if (wb_ack) begin
                    line_clr  = 1'b1;
                    walk_step = 1'b1;
                    r_d.st    = walk_last ? ST_OUTER : ST_WALK;
                end
            end
            ST_OUTER: begin
                if (outer_done)
                    r_d.st = ST_DONE;
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.mode_wb <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign wb_req    = (r_q.st == ST_WB_WAIT);
    assign outer_req = (r_q.st == ST_OUTER);
    assign outer_wb  = r_q.mode_wb;
    assign done      = (r_q.st == ST_DONE);

    // R7
    wb_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(line_idx)));

    // R5
    wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (line_vld && line_dirty && outer_wb));

    // R8
    outer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_req && !outer_done) |=> (outer_req && $stable(outer_wb)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R9
    done_after_outer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_req && outer_done) |=> done);
endmodule

// File: tb/cache_flush_seq_test.sv
`timescale 1ns/1ps
module cache_flush_seq_test;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_wb = 1'b0;
    logic [2:0] line_idx;
    logic       line_vld, line_dirty, line_clr;
    logic       wb_req, wb_ack, outer_req, outer_wb, outer_done, busy, done;

    always #2.5 clk = ~clk;

    cache_flush_seq #(.LINES(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wb(cmd_wb),
        .line_idx(line_idx), .line_vld(line_vld), .line_dirty(line_dirty),
        .line_clr(line_clr), .wb_req(wb_req), .wb_ack(wb_ack),
        .outer_req(outer_req), .outer_wb(outer_wb), .outer_done(outer_done),
        .busy(busy), .done(done)
    );

    int checks = 0, fails = 0;

    // responders
    logic [3:0] wd = 0, od = 0, wcnt = 0, ocnt = 0;
    always @(posedge clk) wcnt <= wb_req ? wcnt + 4'd1 : 4'd0;
    always @(posedge clk) ocnt <= outer_req ? ocnt + 4'd1 : 4'd0;
    assign wb_ack     = wb_req && (wcnt == wd);
    assign outer_done = outer_req && (ocnt == od);

    // cache state model and monitors
    logic       ld = 1'b0;
    logic [7:0] ld_v = 0, ld_d = 0;
    logic [7:0] mvld, mdty, wbmask;
    int wbcnt, clrcnt, order_err, stall_err, outer_err, busycnt, donecnt, outer_seen;
    logic [2:0] next_clr, prev_idx;
    logic       prev_wait;

    assign line_vld   = mvld[line_idx];
    assign line_dirty = mdty[line_idx];

    always @(posedge clk) begin
        if (ld) begin
            mvld <= ld_v; mdty <= ld_d; wbmask <= 0;
            wbcnt <= 0; clrcnt <= 0; order_err <= 0; stall_err <= 0;
            outer_err <= 0; busycnt <= 0; donecnt <= 0; outer_seen <= -1;
            next_clr <= 0; prev_wait <= 0; prev_idx <= 0;
        end else begin
            if (line_clr) begin
                mvld[line_idx] <= 1'b0;
                mdty[line_idx] <= 1'b0;
                clrcnt <= clrcnt + 1;
                if (line_idx != next_clr) order_err <= order_err + 1;
                next_clr <= next_clr + 3'd1;
            end
            if (wb_req && wb_ack) begin
                wbcnt <= wbcnt + 1;
                wbmask[line_idx] <= 1'b1;
            end
            if (prev_wait && line_idx != prev_idx) stall_err <= stall_err + 1;
            prev_wait <= wb_req && !wb_ack;
            prev_idx  <= line_idx;
            if (outer_req && mvld != 8'h00) outer_err <= outer_err + 1;
            if (outer_req) outer_seen <= int'(outer_wb);
            if (busy) busycnt <= busycnt + 1;
            if (done) donecnt <= donecnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] v, input logic [7:0] d);
        @(negedge clk); ld = 1'b1; ld_v = v; ld_d = d;
        @(negedge clk); ld = 1'b0;
    endtask

    // run one flush; noise=1 pulses opposite-kind commands while busy
    task automatic run(input bit m, input logic [7:0] v, input logic [7:0] d,
                       input logic [3:0] a, input logic [3:0] b, input bit noise);
        int w, lim, expb;
        wd = a; od = b;
        load(v, d);
        @(negedge clk); cmd_valid = 1'b1; cmd_wb = m;
        @(negedge clk); cmd_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
        lim = 0;
        while (!done && lim < 400) begin
            if (noise) begin cmd_valid = 1'b1; cmd_wb = ~m; end
            @(negedge clk);
            cmd_valid = 1'b0;
            lim++;
        end
        chk(done == 1'b1, "R9 done reached", int'(done), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy low after done", int'(busy), 0);
        w = m ? $countones(v & d) : 0;
        expb = N + w * (int'(a) + 1) + int'(b) + 1 + 1;
        chk(wbcnt == w, m ? "R5 writeback count" : "R4 no writeback", wbcnt, w);
        chk(wbmask == (m ? (v & d) : 8'h00), "R6 writeback lines", int'(wbmask), int'(m ? (v & d) : 8'h00));
        chk(clrcnt == N && order_err == 0, "R3 clear order", clrcnt, N);
        chk(mvld == 8'h00, "R4 all lines invalid", int'(mvld), 0);
        chk(stall_err == 0, "R7 index held in stall", stall_err, 0);
        chk(outer_err == 0, "R8 outer after local", outer_err, 0);
        chk(outer_seen == int'(m), "R8 outer kind", outer_seen, int'(m));
        chk(donecnt == 1, "R9 done width", donecnt, 1);
        chk(busycnt == expb, "R11 busy cycles", busycnt, expb);
    endtask

    // {kind, valid[7:0], dirty[7:0], ack lag[3:0], outer lag[3:0]}
    localparam logic [24:0] VEC [0:5] = '{
        {1'b0, 8'hFF, 8'hA5, 4'd2, 4'd1},
        {1'b1, 8'hFF, 8'hA5, 4'd2, 4'd0},
        {1'b1, 8'h0F, 8'hF0, 4'd1, 4'd3},
        {1'b1, 8'hFF, 8'hFF, 4'd0, 4'd0},
        {1'b1, 8'h81, 8'h81, 4'd5, 4'd2},
        {1'b0, 8'h00, 8'h00, 4'd0, 4'd0}
    };

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!busy && !done && !line_clr && !wb_req && !outer_req, "R1 reset outputs",
            int'({busy, done, line_clr, wb_req, outer_req}), 0);

        for (int i = 0; i < 6; i++)
            run(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:4], VEC[i][3:0], 1'b0);

        // R10: commands while busy are dropped
        run(1'b1, 8'hFF, 8'hFF, 4'd1, 4'd1, 1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R10 no second flush", int'(busy), 0);
        end
        run(1'b0, 8'h3C, 8'h3C, 4'd0, 4'd2, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule